// File: doc/BRIEF.md
# Receive Byte Aligner with Sync Detect

A deserializer can hand over 8-bit words whose byte boundary sits at any bit position, because its phase alignment gives no guarantee about where one byte ends and the next begins. This block finds the boundary for one receive channel. On every clock it joins the word held from the previous cycle with the present input word into a 16-bit window. It then tests all eight bit offsets of that window in parallel against a sync word. The sync word is the first word of the transmitted pseudo-random sequence, not a separate framing symbol.

When a match is found, the block locks the offset that matched. If several offsets match in the same cycle, it takes the lowest. From then on it emits bytes realigned at that offset and holds its data-valid and locked flags high. The first valid byte is the sync word itself. The rising edge of data-valid is the trigger that starts the expected-value sequence generator in the checker that follows. Lock holds until reset or a resync pulse, after which the search starts again.

Top module: `byte_aligner`

## Requirements
- R1: While reset is asserted (rst_n low), dout is 0, dvalid is 0 and locked is 0.
- R2: While unlocked, and after any input word in which no offset matches, dout stays 0 and dvalid and locked stay 0 after the next clock edge.
- R3: While unlocked with resync low, if any candidate equals SYNC_WORD, then after that clock edge locked and dvalid are 1 and dout equals SYNC_WORD.
- R4: The serial order is MSB first. Candidate k (k = 0..7) is bits [k+7:k] of the window {previous word, current word}, so it takes its k upper bits from the low end of the previous word. Offset 0 is the current word unchanged.
- R5: When several candidates match in one cycle, the lowest k is locked.
- R6: While locked, after each input word dout equals candidate k of that word at the locked k, one clock edge later, even if the sync word later appears at another offset.
- R7: Once set, dvalid and locked stay 1 until reset or resync.
- R8: Resync high at a clock edge clears locked, dvalid and dout at that edge and takes priority over a match in the same cycle. The search resumes on the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| resync | input | 1 | Drops lock and restarts the search |
| din | input | W | Raw word from the deserializer, arbitrary bit boundary |
| dout | output | W | Realigned word, 0 while unlocked |
| dvalid | output | 1 | Aligned data valid; its rising edge starts the downstream generator |
| locked | output | 1 | Offset is found and held |

## Verification
Every result of this block is due exactly one clock edge after the word that causes it: the lock flags and the sync byte, the realigned data at the held offset, and the clearing caused by resync. The bench drives each word on a falling edge, lets one rising edge pass, and samples on the following falling edge. It computes the expected byte directly from its own serial bit array, treating bit positions before the first word as zero to match the cleared previous-word register. The sweep places the sync word at every bit phase inside random traffic. Directed cases cover a word-aligned sync, two overlapping matches in one window, and resync both after lock and in a matching cycle.

// File: rtl/byte_aligner.sv
module byte_aligner #(
  parameter int          W         = 8,
  parameter logic [W-1:0] SYNC_WORD = 8'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         resync,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dvalid,
  output logic         locked
);
  localparam int OW = $clog2(W);

  logic [W-1:0]   prev;
  logic [2*W-1:0] win;
  logic [W-1:0]   hit;
  logic [OW-1:0]  sel, ofs, ofs_use;

  assign win = {prev, din};

  for (genvar k = 0; k < W; k++) begin : g_cand
    assign hit[k] = (win[k +: W] == SYNC_WORD);
  end

  always_comb begin
    sel = '0;
    for (int k = W - 1; k >= 0; k--)
      if (hit[k]) sel = OW'(k);
  end

  assign ofs_use = locked ? ofs : sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      ofs    <= '0;
      dout   <= '0;
      dvalid <= 1'b0;
      locked <= 1'b0;
    end else begin
      prev <= din;
      if (resync) begin
        ofs    <= '0;
        dout   <= '0;
        dvalid <= 1'b0;
        locked <= 1'b0;
      end else if (locked || (|hit)) begin
        ofs    <= ofs_use;
        dout   <= win[ofs_use +: W];
        dvalid <= 1'b1;
        locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_aligner_chk.sv
module byte_aligner_chk #(
  parameter int          W         = 8,
  parameter logic [W-1:0] SYNC_WORD = 8'hA5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         resync,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         dvalid,
  input logic         locked
);
  logic [W-1:0]   last_in;
  logic [2*W-1:0] wc;
  logic [W-1:0]   m;

  always_ff @(posedge clk)
    if (!rst_n) last_in <= '0;
    else        last_in <= din;

  assign wc = {last_in, din};
  for (genvar k = 0; k < W; k++) begin : g_m
    assign m[k] = (wc[k +: W] == SYNC_WORD);
  end

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid |-> (dout == '0 && !locked));

  p_no_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !resync && m == '0) |=> !dvalid);

  p_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !resync && m != '0) |=> (locked && dvalid && dout == SYNC_WORD));

  p_first_is_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid) |-> dout == SYNC_WORD);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !resync) |=> (dvalid && locked));

  p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!dvalid && !locked && dout == '0));
endmodule

bind byte_aligner byte_aligner_chk #(.W(W), .SYNC_WORD(SYNC_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .resync(resync), .din(din),
  .dout(dout), .dvalid(dvalid), .locked(locked)
);

// File: tb/byte_aligner_test.sv
module byte_aligner_test;
  localparam logic [7:0] SYNC = 8'hA5;
  localparam int NB = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, resync = 1'b0;
  logic [7:0] din = '0, dout;
  logic       dvalid, locked;

  byte_aligner #(.W(8), .SYNC_WORD(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .resync(resync), .din(din),
    .dout(dout), .dvalid(dvalid), .locked(locked)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit sbits [NB];
  logic [31:0] rs = 32'h2545F491;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit rbit();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    return rs[0];
  endfunction

  function automatic logic [7:0] cand(int t, int k);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      int s = 8 * t - k + i;
      c[7 - i] = (s < 0) ? 1'b0 : sbits[s];
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_bits();
    for (int i = 0; i < NB; i++) sbits[i] = 1'b0;
  endtask

  task automatic fill_random(int from, int to);
    for (int i = from; i < to; i++) sbits[i] = rbit();
  endtask

  task automatic put(int pos, logic [7:0] v);
    for (int i = 0; i < 8; i++) sbits[pos + i] = v[7 - i];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; resync = 1'b0; din = 8'hFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dout == 8'h00 && !dvalid && !locked, "R1", "reset outputs",
        {dout, 6'b0, dvalid, locked}, 0);
    din = 8'h00;
    rst_n = 1'b1;
  endtask

  task automatic run(int nwords, int rs_at);
    bit lk = 0, multi = 0;
    int ofs = 0;
    do_reset();
    for (int t = 0; t < nwords; t++) begin
      din = cand(t, 0);
      resync = (t == rs_at);
      @(posedge clk);
      @(negedge clk);
      if (t == rs_at) begin
        lk = 0; multi = 0;
        chk(!dvalid && !locked && dout == 0, "R8", "resync clears",
            {dout, 6'b0, dvalid, locked}, 0);
      end else if (lk) begin
        chk(dout == cand(t, ofs), multi ? "R5" : "R4,R6", "aligned data",
            dout, cand(t, ofs));
        chk(dvalid && locked, "R7", "valid held", {dvalid, locked}, 3);
      end else begin
        int nh = 0, first = -1;
        for (int k = 0; k < 8; k++)
          if (cand(t, k) == SYNC) begin
            nh++;
            if (first < 0) first = k;
          end
        if (nh > 0) begin
          lk = 1; ofs = first; multi = (nh > 1);
          chk(dout == SYNC && dvalid && locked, "R3", "lock on sync",
              {dout, 6'b0, dvalid, locked}, {SYNC, 8'h03});
        end else begin
          chk(dout == 0 && !dvalid && !locked, "R2", "idle before lock",
              {dout, 6'b0, dvalid, locked}, 0);
        end
      end
    end
    resync = 1'b0;
  endtask

  initial begin
    // word-aligned sync at offset 0, then random payload
    clear_bits(); put(0, SYNC); fill_random(8, 8 * 12);
    run(12, -1);

    // no sync anywhere: must stay idle (R2)
    clear_bits();
    run(16, -1);

    // every bit phase inside random traffic
    for (int ph = 0; ph < 8; ph++)
      for (int sd = 0; sd < 4; sd++) begin
        clear_bits(); fill_random(0, 8 * 40);
        put(8 * 10 + ph, SYNC);
        run(40, -1);
      end

    // two overlapping matches in one window: k=2 must win over k=7 (R5)
    clear_bits(); put(25, SYNC); put(30, SYNC); fill_random(40, 8 * 24);
    run(24, -1);

    // resync after lock, then relock at another phase (R8)
    clear_bits(); fill_random(0, 8 * 30);
    put(8 * 5 + 3, SYNC); put(8 * 18 + 6, SYNC);
    run(30, 12);

    // resync in the very cycle the sync becomes visible (R8 priority)
    clear_bits(); put(8 * 20 + 1, SYNC);
    run(28, 21);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule